// File: doc/BRIEF.md
# Programmable Product-Term Logic Block

This block is one sum-of-products cell array of a complex programmable logic device. A 36-bit routed input bus is split into 72 literals, the true and the inverted form of each input bit. A programmable AND plane builds 87 product terms from those literals. Eighty of them are general logic terms. Each of the 16 macrocells ORs a selectable subset of sixteen of these terms. The remaining seven terms are control terms. Four of them are output enables, one is an asynchronous set, one is an asynchronous reset and one is a clock. Each control term has its own polarity inverter, so a single pass can produce either an AND or an OR of literals.

Each macrocell either passes its OR sum straight through or stores it in a flip-flop. The flip-flop is clocked by the global clock or by rising edges of the product-term clock. Macrocell values leave on `mc_out` and are also returned on `fb_out` for the routing bus. All configuration lives in registers that a word-wide port writes while `cfg_load` is high. The array always evaluates from these registers.

Top module: `plb_logic_block`

## Requirements
- R1: Literal 2i is input bit i and literal 2i+1 is its complement; a term whose mask selects literal 2i+1 needs that input low.
- R2: A product term is the AND of the literals its 72-bit mask selects. A term whose mask is all zero evaluates to 0.
- R3: Macrocell m ORs the terms enabled by its 16-bit allocation mask. Bit k selects logic term b+k, where b = min(5m, 64). Any count from 0 to 16 terms is allowed.
- R4: Cells 8 to 15 take term 80 as their output enable when their select bit is 0 and term 81 when it is 1. Cells 0 to 7 choose term 82 or term 83 in the same way.
- R5: Control term 80+j is inverted when polarity bit j is set. Bits 0 to 3 are the enables, bit 4 is set (term 84), bit 5 is reset (term 85) and bit 6 is the clock (term 86).
- R6: A combinational cell (mode bit 0 clear) shows its sum at once. A registered cell on the global clock shows the sum sampled at the last rising clock edge.
- R7: A cell with mode bits 0 and 1 set loads its sum only at a clock edge where term 86 is high and was low at the previous edge.
- R8: The reset term forces every registered cell to 0 at once. The set term forces every registered cell to 1 at once. Reset wins when both are active.
- R9: A configuration write takes effect at a rising edge only while `cfg_load` is high. The kinds are 0 = term mask (index 0 to 86, data[71:0]), 1 = allocation (index 0 to 15, data[15:0]), 2 = cell mode (data[0] registered, data[1] term clock, data[2] enable select) and 3 = polarity (data[6:0]).
- R10: A synchronous `rst` clears every configuration register and flip-flop, so after it `mc_out` and `oe_out` are 0.
- R11: `fb_out` carries the same value as `mc_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | global clock |
| rst | input | 1 | synchronous active-high reset |
| pin_in | input | 36 | routed input bus |
| cfg_load | input | 1 | configuration write enable |
| cfg_kind | input | 2 | configuration target kind |
| cfg_idx | input | 7 | term or cell index |
| cfg_data | input | 72 | configuration word |
| mc_out | output | 16 | macrocell values |
| oe_out | output | 16 | per-cell output enables |
| fb_out | output | 16 | feedback to the routing bus |

## Verification
Directed literal patterns drive each sense of an input against a two-literal term. These show whether true and complement literals are wired the right way round and whether an empty term is forced to 0. Input sequences around the clock edge separate combinational, global-clock and term-clock cells. Walking the set and reset terms on and off in an overlapping order exposes a wrong priority or a missing asynchronous path. Random term masks of one to three literals, random allocation masks, random enable selects and random polarities then test the sum windows and the enable halves against a bench model over many input vectors.

// File: rtl/plb_pkg.sv
package plb_pkg;
    parameter int N_IN    = 36;
    parameter int N_MC    = 16;
    parameter int N_LOGIC = 80;
    parameter int N_CTRL  = 7;
    parameter int WIN     = 16;
    parameter int STRIDE  = 5;

    localparam int N_LIT  = 2 * N_IN;
    localparam int N_TERM = N_LOGIC + N_CTRL;
    localparam int IDX_W  = $clog2(N_TERM);
    localparam int MC_W   = $clog2(N_MC);

    // control term offsets relative to N_LOGIC
    localparam int C_SET  = 4;
    localparam int C_RST  = 5;
    localparam int C_CLK  = 6;

    typedef enum logic [1:0] {
        CFG_TERM  = 2'd0,
        CFG_ALLOC = 2'd1,
        CFG_MODE  = 2'd2,
        CFG_POL   = 2'd3
    } cfg_kind_e;

    typedef struct packed {
        logic oe_sel;   // data[2]
        logic pt_clk;   // data[1]
        logic regd;     // data[0]
    } mc_mode_t;

    function automatic int win_base(input int m);
        int b;
        b = m * STRIDE;
        if (b > N_LOGIC - WIN) b = N_LOGIC - WIN;
        return b;
    endfunction
endpackage

// File: rtl/plb_cfg_regs.sv
module plb_cfg_regs
    import plb_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              load,
    input  logic [1:0]                        kind,
    input  logic [IDX_W-1:0]                  idx,
    input  logic [N_LIT-1:0]                  data,
    output logic [N_TERM-1:0][N_LIT-1:0]      term_mask,
    output logic [N_MC-1:0][WIN-1:0]          alloc,
    output mc_mode_t [N_MC-1:0]               mode,
    output logic [N_CTRL-1:0]                 pol
);
    cfg_kind_e kind_e;
    assign kind_e = cfg_kind_e'(kind);

    always_ff @(posedge clk) begin
        if (rst) begin
            term_mask <= '0;
            alloc     <= '0;
            mode      <= '0;
            pol       <= '0;
        end else if (load) begin
            unique case (kind_e)
                CFG_TERM:  if (int'(idx) < N_TERM) term_mask[idx] <= data;
                CFG_ALLOC: if (int'(idx) < N_MC) alloc[idx[MC_W-1:0]] <= data[WIN-1:0];
                CFG_MODE:  if (int'(idx) < N_MC) mode[idx[MC_W-1:0]] <= mc_mode_t'(data[2:0]);
                CFG_POL:   pol <= data[N_CTRL-1:0];
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/plb_and_array.sv
module plb_and_array
    import plb_pkg::*;
(
    input  logic [N_IN-1:0]              x,
    input  logic [N_TERM-1:0][N_LIT-1:0] term_mask,
    output logic [N_TERM-1:0]            terms
);
    logic [N_LIT-1:0] lit;

    for (genvar i = 0; i < N_IN; i++) begin : g_lit
        assign lit[2*i]   = x[i];
        assign lit[2*i+1] = ~x[i];
    end

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        // empty mask yields 0 so the term adds nothing to a sum
        assign terms[t] = (|term_mask[t]) & ((lit & term_mask[t]) == term_mask[t]);
    end
endmodule

// File: rtl/plb_macrocell.sv
module plb_macrocell
    import plb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sum,
    input  mc_mode_t mode,
    input  logic     pt_edge,
    input  logic     aset,
    input  logic     ares,
    output logic     q
);
    logic ff;
    logic clr_a;
    logic set_a;
    logic cap;

    assign clr_a = ares & mode.regd;
    assign set_a = aset & mode.regd;
    assign cap   = mode.pt_clk ? pt_edge : 1'b1;

    always_ff @(posedge clk or posedge clr_a or posedge set_a) begin
        if (clr_a)      ff <= 1'b0;
        else if (set_a) ff <= 1'b1;
        else if (rst)   ff <= 1'b0;
        else if (cap)   ff <= sum;
    end

    assign q = mode.regd ? ff : sum;
endmodule

// File: rtl/plb_logic_block.sv
module plb_logic_block
    import plb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [N_IN-1:0]     pin_in,
    input  logic                cfg_load,
    input  logic [1:0]          cfg_kind,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [N_LIT-1:0]    cfg_data,
    output logic [N_MC-1:0]     mc_out,
    output logic [N_MC-1:0]     oe_out,
    output logic [N_MC-1:0]     fb_out
);
    logic [N_TERM-1:0][N_LIT-1:0] term_mask;
    logic [N_MC-1:0][WIN-1:0]     alloc;
    mc_mode_t [N_MC-1:0]          mode;
    logic [N_CTRL-1:0]            pol;
    logic [N_TERM-1:0]            terms;
    logic [N_CTRL-1:0]            ctrl;
    logic                         aset_t;
    logic                         ares_t;
    logic                         ptclk_t;
    logic                         pt_q;
    logic                         pt_edge;
    logic [N_MC-1:0]              sum_vec;
    logic [N_MC-1:0]              regd_vec;
    logic [N_MC-1:0]              ptsel_vec;

    plb_cfg_regs u_cfg (
        .clk       (clk),
        .rst       (rst),
        .load      (cfg_load),
        .kind      (cfg_kind),
        .idx       (cfg_idx),
        .data      (cfg_data),
        .term_mask (term_mask),
        .alloc     (alloc),
        .mode      (mode),
        .pol       (pol)
    );

    plb_and_array u_arr (
        .x         (pin_in),
        .term_mask (term_mask),
        .terms     (terms)
    );

    assign ctrl    = terms[N_TERM-1:N_LOGIC] ^ pol;
    assign aset_t  = ctrl[C_SET];
    assign ares_t  = ctrl[C_RST];
    assign ptclk_t = ctrl[C_CLK];

    always_ff @(posedge clk) begin
        if (rst) pt_q <= 1'b0;
        else     pt_q <= ptclk_t;
    end
    assign pt_edge = ptclk_t & ~pt_q;

    for (genvar m = 0; m < N_MC; m++) begin : g_mc
        localparam int BASE = win_base(m);

        assign sum_vec[m]   = |(alloc[m] & terms[BASE +: WIN]);
        assign regd_vec[m]  = mode[m].regd;
        assign ptsel_vec[m] = mode[m].regd & mode[m].pt_clk;

        plb_macrocell u_mc (
            .clk     (clk),
            .rst     (rst),
            .sum     (sum_vec[m]),
            .mode    (mode[m]),
            .pt_edge (pt_edge),
            .aset    (aset_t),
            .ares    (ares_t),
            .q       (mc_out[m])
        );

        if (m >= N_MC / 2) begin : g_oe_hi
            assign oe_out[m] = mode[m].oe_sel ? ctrl[1] : ctrl[0];
        end else begin : g_oe_lo
            assign oe_out[m] = mode[m].oe_sel ? ctrl[3] : ctrl[2];
        end
    end

    assign fb_out = mc_out;
endmodule

// File: rtl/plb_logic_block_chk.sv
module plb_logic_block_chk
    import plb_pkg::*;
(
    input logic                         clk,
    input logic                         rst,
    input logic                         cfg_load,
    input logic [N_TERM-1:0][N_LIT-1:0] term_mask,
    input logic [N_MC-1:0][WIN-1:0]     alloc,
    input mc_mode_t [N_MC-1:0]          mode,
    input logic [N_CTRL-1:0]            pol,
    input logic [N_MC-1:0]              mc_out,
    input logic [N_MC-1:0]              oe_out,
    input logic                         aset_t,
    input logic                         ares_t,
    input logic                         ptclk_t,
    input logic [N_MC-1:0]              sum_vec,
    input logic [N_MC-1:0]              regd_vec,
    input logic [N_MC-1:0]              ptsel_vec
);
    logic [N_MC-1:0] gmask;
    assign gmask = regd_vec & ~ptsel_vec;

    // R10
    rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (mc_out == '0 && oe_out == '0));

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_load |=> ($stable(term_mask) && $stable(alloc) && $stable(mode) && $stable(pol)));

    // R8
    ares_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ares_t |-> ((mc_out & regd_vec) == '0));

    // R8
    aset_force_chk: assert property (@(posedge clk) disable iff (rst)
        (aset_t && !ares_t) |-> ((mc_out & regd_vec) == regd_vec));

    // R6
    gclk_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !ares_t && !aset_t && !$past(ares_t) && !$past(aset_t) && $stable(gmask))
        |-> ((mc_out & gmask) == ($past(sum_vec) & gmask)));

    // R7
    ptclk_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && !($past(ptclk_t) && !$past(ptclk_t, 2))
         && !ares_t && !aset_t && !$past(ares_t) && !$past(aset_t) && $stable(ptsel_vec))
        |-> ((mc_out & ptsel_vec) == ($past(mc_out) & ptsel_vec)));
endmodule

bind plb_logic_block plb_logic_block_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .cfg_load  (cfg_load),
    .term_mask (term_mask),
    .alloc     (alloc),
    .mode      (mode),
    .pol       (pol),
    .mc_out    (mc_out),
    .oe_out    (oe_out),
    .aset_t    (aset_t),
    .ares_t    (ares_t),
    .ptclk_t   (ptclk_t),
    .sum_vec   (sum_vec),
    .regd_vec  (regd_vec),
    .ptsel_vec (ptsel_vec)
);

// File: tb/plb_logic_block_tb_top.sv
module plb_logic_block_tb_top;
    import plb_pkg::*;

    logic              clk;
    logic              rst;
    logic [N_IN-1:0]   pin_in;
    logic              cfg_load;
    logic [1:0]        cfg_kind;
    logic [IDX_W-1:0]  cfg_idx;
    logic [N_LIT-1:0]  cfg_data;
    logic [N_MC-1:0]   mc_out;
    logic [N_MC-1:0]   oe_out;
    logic [N_MC-1:0]   fb_out;

    plb_logic_block dut_i (
        .clk(clk), .rst(rst), .pin_in(pin_in), .cfg_load(cfg_load),
        .cfg_kind(cfg_kind), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .mc_out(mc_out), .oe_out(oe_out), .fb_out(fb_out)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    logic [N_LIT-1:0] m_term  [N_TERM];
    logic [WIN-1:0]   m_alloc [N_MC];
    logic [2:0]       m_mode  [N_MC];
    logic [N_CTRL-1:0] m_pol;
    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;
    logic [N_IN-1:0] cur;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic f_pt(input logic [N_LIT-1:0] m, input logic [N_IN-1:0] x);
        logic [N_LIT-1:0] l;
        for (int i = 0; i < N_IN; i++) begin
            l[2*i] = x[i];
            l[2*i+1] = !x[i];
        end
        if (m == '0) return 1'b0;
        return (l & m) == m;
    endfunction

    function automatic logic [15:0] f_sums(input logic [N_IN-1:0] x);
        logic [15:0] r = '0;
        for (int c = 0; c < N_MC; c++) begin
            int b = (c * 5 > 64) ? 64 : c * 5;
            for (int k = 0; k < WIN; k++)
                if (m_alloc[c][k] && f_pt(m_term[b+k], x)) r[c] = 1'b1;
        end
        return r;
    endfunction

    function automatic logic [15:0] f_oes(input logic [N_IN-1:0] x);
        logic [15:0] r;
        for (int c = 0; c < N_MC; c++) begin
            int w = (c >= 8) ? (m_mode[c][2] ? 1 : 0) : (m_mode[c][2] ? 3 : 2);
            r[c] = f_pt(m_term[80+w], x) ^ m_pol[w];
        end
        return r;
    endfunction

    task automatic wr(input int kind, input int idx, input logic [N_LIT-1:0] d, input bit en);
        @(negedge clk);
        cfg_load = en; cfg_kind = kind[1:0]; cfg_idx = idx[IDX_W-1:0]; cfg_data = d;
        @(negedge clk);
        cfg_load = 1'b0;
        if (en) begin
            case (kind)
                0: m_term[idx] = d;
                1: m_alloc[idx] = d[WIN-1:0];
                2: m_mode[idx] = d[2:0];
                default: m_pol = d[N_CTRL-1:0];
            endcase
        end
    endtask

    task automatic drive(input logic [N_IN-1:0] x);
        @(negedge clk);
        cur = x;
        pin_in = x;
        #1;
    endtask

    initial begin
        #(10 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int t = 0; t < N_TERM; t++) m_term[t] = '0;
        for (int c = 0; c < N_MC; c++) begin m_alloc[c] = '0; m_mode[c] = '0; end
        m_pol = '0;
        rst = 1'b1; cfg_load = 1'b0; cfg_kind = '0; cfg_idx = '0; cfg_data = '0;
        pin_in = {N_IN{1'b1}}; cur = pin_in;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R10 mc_out after reset", mc_out, 16'h0);
        chk("R10 oe_out after reset", oe_out, 16'h0);

        // directed configuration
        wr(0, 0, 72'h1 << 6 | 72'h1 << 11, 1);   // in[3] & ~in[5]
        wr(1, 0, 72'h1, 1);
        wr(1, 1, 72'h1, 1);                      // term 5 left empty
        wr(0, 79, 72'h1, 1);                     // in[0]
        wr(1, 15, 72'h8000, 1);
        drive('0);
        drive(36'h008);
        chk("R1 true and complement literal", {15'h0, mc_out[0]}, 16'h1);
        chk("R11 feedback", fb_out, mc_out);
        drive(36'h028);
        chk("R1 complement literal blocks", {15'h0, mc_out[0]}, 16'h0);
        drive({N_IN{1'b1}});
        chk("R2 empty term is zero", {15'h0, mc_out[1]}, 16'h0);
        drive(36'h001);
        chk("R3 top window term 79", {15'h0, mc_out[15]}, 16'h1);
        drive(36'h000);
        chk("R3 top window term 79 low", {15'h0, mc_out[15]}, 16'h0);

        // output enables and polarity
        wr(3, 0, 72'h1, 1);
        #1 chk("R5 inverted empty enable", oe_out, 16'hFF00);
        wr(2, 15, 72'h4, 1);
        #1 chk("R4 upper half select", oe_out, 16'h7F00);
        wr(0, 82, 72'h1 << 2, 1);                // in[1]
        drive(36'h002);
        chk("R4 lower half term 82", oe_out, 16'h7FFF);

        // registered cells
        wr(0, 10, 72'h1 << 14, 1);               // in[7]
        wr(1, 2, 72'h1, 1);
        wr(2, 2, 72'h1, 1);
        wr(0, 15, 72'h1 << 16, 1);               // in[8]
        wr(1, 3, 72'h1, 1);
        wr(2, 3, 72'h3, 1);
        wr(0, 86, 72'h1 << 18, 1);               // in[9]
        wr(0, 84, 72'h1 << 20, 1);               // in[10]
        wr(0, 85, 72'h1 << 22, 1);               // in[11]
        drive('0);
        drive(36'h080);
        chk("R6 registered before edge", {15'h0, mc_out[2]}, 16'h0);
        @(negedge clk); #1;
        chk("R6 registered after edge", {15'h0, mc_out[2]}, 16'h1);
        drive(36'h000);
        chk("R6 registered holds", {15'h0, mc_out[2]}, 16'h1);
        @(negedge clk); #1;
        chk("R6 registered clears", {15'h0, mc_out[2]}, 16'h0);

        drive(36'h100);
        @(negedge clk); #1;
        chk("R7 no term clock edge", {15'h0, mc_out[3]}, 16'h0);
        drive(36'h300);
        chk("R7 before edge", {15'h0, mc_out[3]}, 16'h0);
        @(negedge clk); #1;
        chk("R7 captured on term clock rise", {15'h0, mc_out[3]}, 16'h1);
        drive(36'h200);
        @(negedge clk); #1;
        chk("R7 clock held high no capture", {15'h0, mc_out[3]}, 16'h1);
        drive(36'h000);
        drive(36'h200);
        @(negedge clk); #1;
        chk("R7 second rise captures", {15'h0, mc_out[3]}, 16'h0);

        // asynchronous set and reset
        drive(36'h600);
        chk("R8 async set immediate", {14'h0, mc_out[3:2]}, 16'h3);
        chk("R8 combinational cell untouched", {15'h0, mc_out[0]}, 16'h0);
        drive(36'h200);
        chk("R8 set released holds", {14'h0, mc_out[3:2]}, 16'h3);
        drive(36'hA00);
        chk("R8 async reset immediate", {14'h0, mc_out[3:2]}, 16'h0);
        drive(36'hE00);
        chk("R8 reset wins over set", {14'h0, mc_out[3:2]}, 16'h0);
        drive(36'h200);
        @(negedge clk); #1;
        chk("R8 both released", {14'h0, mc_out[3:2]}, 16'h0);

        // load enable low
        drive(36'h008);
        wr(0, 0, 72'h0, 0);
        wr(1, 0, 72'h0, 0);
        #1 chk("R9 write ignored without load", {15'h0, mc_out[0]}, 16'h1);

        // random all-combinational rounds
        for (int round = 0; round < 3; round++) begin
            drive('0);
            for (int c = 0; c < N_MC; c++) wr(2, c, {69'h0, 1'($urandom % 2), 2'b00}, 1);
            wr(3, 0, {68'h0, 4'($urandom % 16)}, 1);
            for (int t = 0; t < N_TERM; t++) begin
                logic [N_LIT-1:0] m = '0;
                if (t < 84) repeat (1 + $urandom % 3) m[$urandom % N_LIT] = 1'b1;
                wr(0, t, m, 1);
            end
            for (int c = 0; c < N_MC; c++) wr(1, c, {56'h0, 16'($urandom)}, 1);
            for (int v = 0; v < 80; v++) begin
                logic [N_IN-1:0] x = {4'($urandom), 32'($urandom)};
                drive(x);
                chk("R3 random sums", mc_out, f_sums(x));
                chk("R4 random enables", oe_out, f_oes(x));
                if (v % 20 == 0) chk("R11 random feedback", fb_out, f_sums(x));
            end
        end

        // reset clears again
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R10 second reset mc_out", mc_out, 16'h0);
        chk("R10 second reset oe_out", oe_out, 16'h0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule